// File: doc/BRIEF.md
# Dual-Port Instruction Completion Watchdog

This block observes the two instruction-completion ports of a processor core and decides, interval by interval, whether the core is making progress. Each port carries a completion flag and a word address. The byte address is the word address shifted left by two. After reset is released and a programmable settle period has passed, every clock cycle with `sample_en` high counts as one sampling interval. In each interval the block compares the completion state with a stored reference and updates two threshold counters.

One counter measures spinning. It advances on an interval that repeats the reference while at most one port completes. An interval in which both ports complete is treated as normal progress, so it does not advance the counter. The other counter measures hanging, which is a run of intervals with no completion at all. A completion at either of two fixed byte addresses reports a pass or a fail verdict. All four verdicts are sticky. Once any of them is raised, `done` stays high and evaluation stops until the next reset.

Top module: `cpl_watchdog`

## Requirements
- R1: While reset is asserted, and right after it, `pass_o`, `fail_o`, `hang_o`, `loop_o`, `done_o` and `armed_o` are all 0.
- R2: `armed_o` rises at the (settle_cycles+3)-th rising clock edge after `rst_n` is released. This comprises two edges of reset synchronisation plus settle_cycles+1 counting edges. No interval is evaluated before `armed_o` is high, so a pass-address completion during settling raises nothing.
- R3: An interval is a clock edge at which `sample_en` is 1, `armed_o` is 1 and `done_o` is 0. With `sample_en` at 0, no counter or flag moves.
- R4: `pass_o` is set when a port has its completion flag at 1 and its byte address {waddr,2'b00} equals PASS_BYTE_ADDR, which defaults to 0x7F0 (word 0x1FC). `fail_o` is set in the same way for FAIL_BYTE_ADDR, which defaults to 0x7F4 (word 0x1FD). A port whose completion flag is 0 never matches. Both flags may be set in the same interval.
- R5: An interval is unchanged when, on each port, the completion flag equals the reference flag, and a completing port also has the reference address. The address of a port that is not completing is ignored. Any other interval is changed. A changed interval clears the loop counter and becomes the new reference. After reset the reference has both flags at 0.
- R6: An unchanged interval advances the loop counter only when at least one port is not completing. An unchanged interval with both ports completing leaves the counter as it is.
- R7: `loop_o` is set in the interval in which the loop counter reaches `loop_limit`. A `loop_limit` of 0 disables loop detection.
- R8: `hang_o` is set in the `hang_limit`-th consecutive interval without any completion. Any completing interval restarts that count. A `hang_limit` of 0 disables hang detection.
- R9: `done_o` is the OR of the four verdict flags. Once it is high, no later interval is evaluated and all flags are frozen until reset.
- R10: Every verdict flag stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_en | input | 1 | Marks a sampling interval |
| settle_cycles | input | CW | Clock cycles to wait after reset before arming |
| hang_limit | input | CW | Idle intervals before a hang is flagged, 0 = off |
| loop_limit | input | CW | Repeated intervals before a loop is flagged, 0 = off |
| p0_cpl | input | 1 | Port 0 completion flag |
| p0_waddr | input | AW | Port 0 completed word address |
| p1_cpl | input | 1 | Port 1 completion flag |
| p1_waddr | input | AW | Port 1 completed word address |
| armed_o | output | 1 | Settle period over, intervals are evaluated |
| pass_o | output | 1 | Sticky pass verdict |
| fail_o | output | 1 | Sticky fail verdict |
| hang_o | output | 1 | Sticky hang verdict |
| loop_o | output | 1 | Sticky loop verdict |
| done_o | output | 1 | Any verdict raised |

## Verification
Some properties are checked by assertions on every cycle. These are the stickiness of each verdict and of the armed state, the freeze of all flags once done is high, the absence of any verdict before arming, the rule that a zero threshold never trips, and the rule that the reference follows the inputs after a changed interval. Other behaviour can only be shown by the bench's sweeps. These are the exact arming edge for each settle value, the exact interval in which each loop or hang limit trips, the restart of the counts on a change or on a completion, the port-1 address being ignored when port 1 is idle, dual completions not being counted, and the near-miss addresses around pass and fail.

// File: rtl/cpl_wd_pkg.sv
package cpl_wd_pkg;

  localparam int unsigned CPL_PORTS = 2;

  typedef enum logic [1:0] {
    IVL_CHANGED   = 2'd0,
    IVL_SAME_SPIN = 2'd1,
    IVL_SAME_DUAL = 2'd2
  } ivl_kind_e;

endpackage

// File: rtl/cpl_wd_settle.sv
module cpl_wd_settle #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] settle,
  output logic          armed
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (!armed_q) begin
      if (cnt_q == settle) armed_d = 1'b1;
      else                 cnt_d   = cnt_q + {{(CW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q); // R2

endmodule

// File: rtl/cpl_wd_change.sv
module cpl_wd_change
  import cpl_wd_pkg::*;
#(
  parameter int unsigned NP = 2,
  parameter int unsigned AW = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [NP-1:0]    vld,
  input  logic [NP*AW-1:0] waddr,
  output ivl_kind_e        kind,
  output logic             any_cpl
);

  logic [NP-1:0]    ref_vld_q, ref_vld_d;
  logic [NP*AW-1:0] ref_addr_q, ref_addr_d;
  logic [NP-1:0]    same;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign same[p] = (vld[p] == ref_vld_q[p]) &&
                     (!vld[p] || (waddr[p*AW +: AW] == ref_addr_q[p*AW +: AW]));
  end

  always_comb begin
    if (!(&same))      kind = IVL_CHANGED;
    else if (&vld)     kind = IVL_SAME_DUAL;
    else               kind = IVL_SAME_SPIN;
  end

  assign any_cpl = |vld;

  always_comb begin
    ref_vld_d  = ref_vld_q;
    ref_addr_d = ref_addr_q;
    if (upd_en && (kind == IVL_CHANGED)) begin
      ref_vld_d  = vld;
      ref_addr_d = waddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_vld_q  <= '0;
      ref_addr_q <= '0;
    end else begin
      ref_vld_q  <= ref_vld_d;
      ref_addr_q <= ref_addr_d;
    end
  end

  AST_REF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && kind == IVL_CHANGED) |=> (ref_vld_q == $past(vld))); // R5

endmodule

// File: rtl/cpl_wd_limit.sv
module cpl_wd_limit #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          flag
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic [CW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (en) begin
      if (clr) begin
        cnt_d = '0;
      end else if (step) begin
        if (!cnt_inc[CW]) cnt_d = cnt_inc[CW-1:0];
        if ((limit != '0) && (cnt_inc >= {1'b0, limit})) flag_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !flag_q) |=> !flag_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q); // R10

endmodule

// File: rtl/cpl_wd_match.sv
module cpl_wd_match #(
  parameter int unsigned        NP   = 2,
  parameter int unsigned        AW   = 30,
  parameter logic [AW+1:0]      PASS = 32'h7F0,
  parameter logic [AW+1:0]      FAIL = 32'h7F4
) (
  input  logic [NP-1:0]    vld,
  input  logic [NP*AW-1:0] waddr,
  output logic             pass_hit,
  output logic             fail_hit
);

  logic [NP-1:0] p_hit, f_hit;

  for (genvar p = 0; p < NP; p++) begin : g_cmp
    logic [AW+1:0] baddr;
    assign baddr    = {waddr[p*AW +: AW], 2'b00};
    assign p_hit[p] = vld[p] && (baddr == PASS);
    assign f_hit[p] = vld[p] && (baddr == FAIL);
  end

  assign pass_hit = |p_hit;
  assign fail_hit = |f_hit;

endmodule

// File: rtl/cpl_watchdog.sv
module cpl_watchdog
  import cpl_wd_pkg::*;
#(
  parameter int unsigned   AW             = 30,
  parameter int unsigned   CW             = 16,
  parameter logic [AW+1:0] PASS_BYTE_ADDR = 32'h7F0,
  parameter logic [AW+1:0] FAIL_BYTE_ADDR = 32'h7F4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic [CW-1:0] settle_cycles,
  input  logic [CW-1:0] hang_limit,
  input  logic [CW-1:0] loop_limit,
  input  logic          p0_cpl,
  input  logic [AW-1:0] p0_waddr,
  input  logic          p1_cpl,
  input  logic [AW-1:0] p1_waddr,
  output logic          armed_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          hang_o,
  output logic          loop_o,
  output logic          done_o
);

  localparam int unsigned NP = CPL_PORTS;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NP-1:0]    vld;
  logic [NP*AW-1:0] waddr;
  logic             active;
  ivl_kind_e        kind;
  logic             any_cpl;
  logic             pass_hit, fail_hit;
  logic             pass_q, pass_d, fail_q, fail_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign vld   = {p1_cpl, p0_cpl};
  assign waddr = {p1_waddr, p0_waddr};

  cpl_wd_settle #(.CW(CW)) u_settle (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .settle (settle_cycles),
    .armed  (armed_o)
  );

  assign active = armed_o && sample_en && !done_o;

  cpl_wd_change #(.NP(NP), .AW(AW)) u_change (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .upd_en  (active),
    .vld     (vld),
    .waddr   (waddr),
    .kind    (kind),
    .any_cpl (any_cpl)
  );

  cpl_wd_limit #(.CW(CW)) u_loop (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (active),
    .step  (kind == IVL_SAME_SPIN),
    .clr   (kind == IVL_CHANGED),
    .limit (loop_limit),
    .flag  (loop_o)
  );

  cpl_wd_limit #(.CW(CW)) u_hang (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (active),
    .step  (!any_cpl),
    .clr   (any_cpl),
    .limit (hang_limit),
    .flag  (hang_o)
  );

  cpl_wd_match #(.NP(NP), .AW(AW), .PASS(PASS_BYTE_ADDR), .FAIL(FAIL_BYTE_ADDR)) u_match (
    .vld      (vld),
    .waddr    (waddr),
    .pass_hit (pass_hit),
    .fail_hit (fail_hit)
  );

  always_comb begin
    pass_d = pass_q;
    fail_d = fail_q;
    if (active) begin
      if (pass_hit) pass_d = 1'b1;
      if (fail_hit) fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign done_o = pass_q | fail_q | hang_o | loop_o;

  AST_NO_VERDICT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_o |-> !done_o); // R2

  AST_PASS_IN_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> $past(sample_en && armed_o)); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R9

  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_o) |-> $stable({pass_o, fail_o, hang_o, loop_o})); // R9

  AST_HANG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (hang_limit == '0 && !hang_o) |=> !hang_o); // R8

endmodule

// File: tb/cpl_watchdog_bench.sv
module cpl_watchdog_bench;

  localparam int unsigned AW = 30;
  localparam int unsigned CW = 16;
  localparam logic [AW-1:0] W_PASS = 30'h1FC;
  localparam logic [AW-1:0] W_FAIL = 30'h1FD;

  logic          clk;
  logic          rst_n;
  logic          sample_en;
  logic [CW-1:0] settle_cycles, hang_limit, loop_limit;
  logic          p0_cpl, p1_cpl;
  logic [AW-1:0] p0_waddr, p1_waddr;
  logic          armed_o, pass_o, fail_o, hang_o, loop_o, done_o;

  int checks = 0;
  int errors = 0;

  cpl_watchdog u_cpl_watchdog (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .settle_cycles(settle_cycles), .hang_limit(hang_limit), .loop_limit(loop_limit),
    .p0_cpl(p0_cpl), .p0_waddr(p0_waddr), .p1_cpl(p1_cpl), .p1_waddr(p1_waddr),
    .armed_o(armed_o), .pass_o(pass_o), .fail_o(fail_o),
    .hang_o(hang_o), .loop_o(loop_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_in(input logic c0, input logic [AW-1:0] a0,
                        input logic c1, input logic [AW-1:0] a1);
    p0_cpl = c0; p0_waddr = a0; p1_cpl = c1; p1_waddr = a1;
  endtask

  // reset, configure, wait for arming; returns edges counted after release
  task automatic start(input int s, input int h, input int l, input logic poison, output int n);
    @(negedge clk);
    rst_n = 1'b0;
    settle_cycles = CW'(s); hang_limit = CW'(h); loop_limit = CW'(l);
    sample_en = poison;
    if (poison) set_in(1'b1, W_PASS, 1'b1, W_FAIL);
    else        set_in(1'b0, '0, 1'b0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #5;
      n++;
    end while (!armed_o && n < 100);
  endtask

  task automatic iv(input logic c0, input logic [AW-1:0] a0,
                    input logic c1, input logic [AW-1:0] a1);
    @(negedge clk);
    sample_en = 1'b1;
    set_in(c0, a0, c1, a1);
    @(posedge clk); #5;
  endtask

  task automatic quiet(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      sample_en = 1'b0;
      set_in(1'b0, '0, 1'b0, '0);
      @(posedge clk); #5;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; sample_en = 1'b0;
    settle_cycles = '0; hang_limit = '0; loop_limit = '0;
    set_in(1'b0, '0, 1'b0, '0);
    repeat (2) @(posedge clk); #5;
    // R1 reset state
    chk("R1", "flags in reset", {armed_o, pass_o, fail_o, hang_o, loop_o, done_o}, 0);

    // R2 settle sweep
    for (int s = 0; s < 6; s++) begin
      start(s, 0, 0, 1'b0, n);
      chk("R2", "arming edge", n, s + 3);
    end
    // R2 completions during settling are not evaluated
    start(4, 0, 0, 1'b1, n);
    quiet(1);
    chk("R2", "pass before arm", pass_o, 0);
    chk("R2", "fail before arm", fail_o, 0);
    chk("R1", "outputs after arm", {pass_o, fail_o, hang_o, loop_o, done_o}, 0);

    // R4 pass / fail decoding and near misses
    start(1, 0, 0, 1'b0, n);
    iv(1'b0, '0, 1'b1, 30'h1FE);
    iv(1'b1, 30'h1FB, 1'b0, '0);
    iv(1'b0, W_PASS, 1'b0, W_FAIL);
    chk("R4", "near miss / idle port", {pass_o, fail_o, done_o}, 0);
    iv(1'b0, '0, 1'b1, W_PASS);
    chk("R4", "pass on port1", pass_o, 1);
    chk("R9", "done on pass", done_o, 1);
    iv(1'b1, W_FAIL, 1'b0, '0);
    chk("R9", "fail frozen after done", fail_o, 0);
    quiet(3);
    chk("R10", "pass sticky", pass_o, 1);

    start(0, 0, 0, 1'b0, n);
    iv(1'b1, W_FAIL, 1'b0, '0);
    chk("R4", "fail on port0", {pass_o, fail_o}, 1);
    start(0, 0, 0, 1'b0, n);
    iv(1'b1, W_PASS, 1'b1, W_FAIL);
    chk("R4", "pass and fail same interval", {pass_o, fail_o}, 3);

    // R7 loop threshold sweep
    for (int l = 1; l < 6; l++) begin
      start(0, 0, l, 1'b0, n);
      iv(1'b1, 30'h10, 1'b0, '0);
      for (int j = 1; j < l; j++) iv(1'b1, 30'h10, 1'b0, '0);
      chk("R7", $sformatf("loop before limit %0d", l), loop_o, 0);
      iv(1'b1, 30'h10, 1'b0, '0);
      chk("R7", $sformatf("loop at limit %0d", l), loop_o, 1);
      chk("R9", "done on loop", done_o, 1);
    end
    start(0, 0, 0, 1'b0, n);
    for (int j = 0; j < 30; j++) iv(1'b1, 30'h10, 1'b0, '0);
    chk("R7", "loop limit zero", {loop_o, done_o}, 0);

    // R5 change clears the loop count
    start(0, 0, 3, 1'b0, n);
    iv(1'b1, 30'h20, 1'b0, '0);
    iv(1'b1, 30'h20, 1'b0, '0);
    iv(1'b1, 30'h20, 1'b0, '0);
    iv(1'b1, 30'h21, 1'b0, '0);
    iv(1'b1, 30'h21, 1'b0, '0);
    iv(1'b1, 30'h21, 1'b0, '0);
    chk("R5", "count cleared by change", loop_o, 0);
    iv(1'b1, 30'h21, 1'b0, '0);
    chk("R5", "count after new reference", loop_o, 1);

    // R5 idle port address ignored
    start(0, 0, 3, 1'b0, n);
    iv(1'b1, 30'h20, 1'b0, 30'h5);
    iv(1'b1, 30'h20, 1'b0, 30'h6);
    iv(1'b1, 30'h20, 1'b0, 30'h7);
    chk("R5", "idle port addr ignored, before", loop_o, 0);
    iv(1'b1, 30'h20, 1'b0, 30'h8);
    chk("R5", "idle port addr ignored, trip", loop_o, 1);

    // R5 moving address never loops
    start(0, 0, 2, 1'b0, n);
    for (int j = 0; j < 10; j++) iv(1'b1, 30'h40 + 30'(j), 1'b0, '0);
    chk("R5", "progressing address", loop_o, 0);

    // R6 dual completion not counted
    start(0, 0, 2, 1'b0, n);
    for (int j = 0; j < 7; j++) iv(1'b1, 30'h30, 1'b1, 30'h31);
    chk("R6", "dual repeat not counted", loop_o, 0);
    iv(1'b1, 30'h30, 1'b0, '0);
    iv(1'b1, 30'h30, 1'b0, '0);
    chk("R6", "single repeat 1", loop_o, 0);
    iv(1'b1, 30'h30, 1'b0, '0);
    chk("R6", "single repeat 2", loop_o, 1);

    // R8 hang threshold sweep
    for (int h = 1; h < 7; h++) begin
      start(0, h, 0, 1'b0, n);
      for (int j = 1; j < h; j++) iv(1'b0, '0, 1'b0, '0);
      chk("R8", $sformatf("hang before limit %0d", h), hang_o, 0);
      iv(1'b0, '0, 1'b0, '0);
      chk("R8", $sformatf("hang at limit %0d", h), hang_o, 1);
    end
    start(0, 4, 0, 1'b0, n);
    for (int j = 0; j < 3; j++) iv(1'b0, '0, 1'b0, '0);
    iv(1'b0, '0, 1'b1, 30'h77);
    for (int j = 0; j < 3; j++) iv(1'b0, '0, 1'b0, '0);
    chk("R8", "completion restarts hang count", hang_o, 0);
    iv(1'b0, '0, 1'b0, '0);
    chk("R8", "hang after restart", hang_o, 1);
    start(0, 0, 0, 1'b0, n);
    for (int j = 0; j < 40; j++) iv(1'b0, '0, 1'b0, '0);
    chk("R8", "hang limit zero", hang_o, 0);

    // R3 sample_en low is not an interval
    start(0, 2, 0, 1'b0, n);
    quiet(10);
    chk("R3", "no interval without sample_en", hang_o, 0);
    iv(1'b0, '0, 1'b0, '0);
    iv(1'b0, '0, 1'b0, '0);
    chk("R3", "intervals with sample_en", hang_o, 1);

    // R9 freeze: loop trips first, hang must not follow
    start(0, 2, 1, 1'b0, n);
    iv(1'b0, '0, 1'b0, '0);
    chk("R9", "loop first", {hang_o, loop_o}, 1);
    iv(1'b0, '0, 1'b0, '0);
    iv(1'b0, '0, 1'b0, '0);
    chk("R9", "hang frozen after done", hang_o, 0);
    chk("R10", "loop sticky", loop_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule